// File: doc/BRIEF.md
# Five-Operand Decimal Adder

This block adds five unsigned packed-BCD operands in a single pass and returns their exact decimal total. Each operand carries `DIGITS` decimal digits, four bits per digit, with every digit between 0 and 9. The result is one digit wider than an operand because the total of five numbers can carry a value of up to 4 out of the top column. For four-digit operands the largest possible total is 49995.

The datapath has three stages. In the first, each digit column feeds its five digits through a carry-save tree. The tree reduces them to a binary column total between 0 and 45.

In the second stage, a decade analyser takes that total and raises a generate flag for each decade boundary it has passed: above 9, above 19, above 29 and above 39. It also raises a propagate flag when the total sits in the top four values of its decade (6..9, 16..19, 26..29, 36..39). In that range an incoming decimal carry can push the total over the next boundary.

In the third stage, the decimal carries are resolved column by column in generate/propagate form. The carry out is the number of decades generated, plus one more when the column propagates and the incoming carry reaches the boundary. The digit left over is the column's final result digit.

The result can be registered behind a clock enable taken from `in_valid`, or passed straight through, as chosen by `REGISTERED`. A flag reports any input digit above 9. When the flag is raised, the sum is undefined.

Top module: `bcd5_sum_adder`

## Requirements
- R1: `sum_bcd` equals the decimal sum of `op_a` through `op_e`, in packed BCD with digit i in bits [4i+3:4i] and the most significant digit in the top nibble.
- R2: When no input digit exceeds 9, every result digit lies in 0..9 and the top result digit lies in 0..4.
- R3: Columns whose total reaches 45 with an incoming carry of 4 are resolved correctly: five operands of all nines give 4 followed by DIGITS-1 nines and a final 5 (49995 for four digits).
- R4: The operands 9234, 4876, 6542, 3435 and 5678 give 29765.
- R5: `invalid_bcd` is 1 after an accepted set of operands in which any digit has a value of 10..15, and 0 after an accepted set in which every digit is 0..9.
- R6: With REGISTERED=1, the sum and flag for operands presented with `in_valid`=1 appear after the next rising clock edge, and `out_valid` is `in_valid` delayed by one cycle.
- R7: With REGISTERED=1, a cycle with `in_valid`=0 leaves `sum_bcd` and `invalid_bcd` unchanged, whatever the operand inputs carry.
- R8: While `rst_n` is low, `sum_bcd` is zero and `out_valid` and `invalid_bcd` are 0.
- R9: Five all-zero operands give a zero sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are presented this cycle; register load enable |
| op_a | input | 4*DIGITS | First BCD operand |
| op_b | input | 4*DIGITS | Second BCD operand |
| op_c | input | 4*DIGITS | Third BCD operand |
| op_d | input | 4*DIGITS | Fourth BCD operand |
| op_e | input | 4*DIGITS | Fifth BCD operand |
| sum_bcd | output | 4*DIGITS+4 | BCD total, one digit wider than an operand |
| out_valid | output | 1 | `sum_bcd` holds a fresh result |
| invalid_bcd | output | 1 | An accepted operand digit exceeded 9 |

## Verification
The bench builds two copies of the block, both registered. The first uses DIGITS=1: a single column whose five digits are swept over all 100000 combinations. This covers every column total from 0 to 45 and every decade boundary that the analyser flags.

The second uses the default DIGITS=4. It exercises carry chains across columns, the worked example, the all-nines and all-zeros operands, a batch of random valid operands, invalid digits and hold cycles. With four columns in the chain, incoming carries of every value from 0 to 4 meet columns that propagate.

// File: rtl/bcd5_pkg.sv
package bcd5_pkg;

  localparam int NOPS   = 5;
  localparam int COLW   = 6;
  localparam int NDEC   = 4;

  typedef logic [3:0]      digit_t;
  typedef logic [COLW-1:0] colsum_t;
  typedef logic [2:0]      dcarry_t;

  typedef struct packed {
    logic [NDEC-1:0] gen;
    logic            prop;
    dcarry_t         q;
    digit_t          rem;
  } decade_t;

  function automatic colsum_t csa_s(colsum_t x, colsum_t y, colsum_t z);
    return x ^ y ^ z;
  endfunction

  function automatic colsum_t csa_c(colsum_t x, colsum_t y, colsum_t z);
    return ((x & y) | (x & z) | (y & z)) << 1;
  endfunction

endpackage

// File: rtl/bcd5_col_reduce.sv
module bcd5_col_reduce
  import bcd5_pkg::*;
(
  input  logic [NOPS-1:0][3:0] digs,
  output colsum_t              col,
  output logic                 bad
);

  colsum_t         ext [NOPS];
  logic [NOPS-1:0] bad_v;

  for (genvar i = 0; i < NOPS; i++) begin : g_ext
    assign ext[i]   = {2'b00, digs[i]};
    assign bad_v[i] = (digs[i] > 4'd9);
  end

  colsum_t s1, c1, s2, c2, s3, c3;

  always_comb begin
    s1 = csa_s(ext[0], ext[1], ext[2]);
    c1 = csa_c(ext[0], ext[1], ext[2]);
    s2 = csa_s(s1, c1, ext[3]);
    c2 = csa_c(s1, c1, ext[3]);
    s3 = csa_s(s2, c2, ext[4]);
    c3 = csa_c(s2, c2, ext[4]);
  end

  assign col = s3 + c3;
  assign bad = |bad_v;

endmodule

// File: rtl/bcd5_decade_analyzer.sv
module bcd5_decade_analyzer
  import bcd5_pkg::*;
(
  input  colsum_t col,
  output decade_t dec
);

  logic [NDEC-1:0] gen;
  dcarry_t         q;
  digit_t          off;
  digit_t          rem;

  for (genvar k = 0; k < NDEC; k++) begin : g_gen
    assign gen[k] = (col > colsum_t'(10 * k + 9));
  end

  always_comb begin
    q = dcarry_t'(gen[0]) + dcarry_t'(gen[1]) + dcarry_t'(gen[2]) + dcarry_t'(gen[3]);
    case (q)
      3'd0:    off = 4'd0;
      3'd1:    off = 4'd10;
      3'd2:    off = 4'd4;
      3'd3:    off = 4'd14;
      default: off = 4'd8;
    endcase
    rem = col[3:0] - off;
  end

  assign dec.gen  = gen;
  assign dec.q    = q;
  assign dec.rem  = rem;
  assign dec.prop = (rem >= 4'd6);

endmodule

// File: rtl/bcd5_carry_resolve.sv
module bcd5_carry_resolve
  import bcd5_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  decade_t [DIGITS-1:0] dec,
  output logic    [DIGITS:0][3:0] dig
);

  always_comb begin
    dcarry_t    c;
    logic [4:0] t;
    logic       wrap;
    c = '0;
    for (int i = 0; i < DIGITS; i++) begin
      t      = {1'b0, dec[i].rem} + {2'b00, c};
      wrap   = dec[i].prop && (t >= 5'd10);
      dig[i] = wrap ? 4'(t - 5'd10) : t[3:0];
      c      = dec[i].q + dcarry_t'(wrap);
    end
    dig[DIGITS] = {1'b0, c};
  end

endmodule

// File: rtl/bcd5_sum_adder.sv
module bcd5_sum_adder
  import bcd5_pkg::*;
#(
  parameter int DIGITS     = 4,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [4*DIGITS-1:0] op_a,
  input  logic [4*DIGITS-1:0] op_b,
  input  logic [4*DIGITS-1:0] op_c,
  input  logic [4*DIGITS-1:0] op_d,
  input  logic [4*DIGITS-1:0] op_e,
  output logic [4*DIGITS+3:0] sum_bcd,
  output logic                out_valid,
  output logic                invalid_bcd
);

  localparam int SUMW = 4 * DIGITS + 4;

  colsum_t        col_sum [DIGITS];
  logic [DIGITS-1:0]   col_bad;
  decade_t [DIGITS-1:0] col_dec;

  for (genvar d = 0; d < DIGITS; d++) begin : g_col
    logic [NOPS-1:0][3:0] digs;
    assign digs = {op_e[4*d +: 4], op_d[4*d +: 4], op_c[4*d +: 4],
                   op_b[4*d +: 4], op_a[4*d +: 4]};

    bcd5_col_reduce u_red (
      .digs (digs),
      .col  (col_sum[d]),
      .bad  (col_bad[d])
    );

    bcd5_decade_analyzer u_ana (
      .col (col_sum[d]),
      .dec (col_dec[d])
    );
  end

  logic [DIGITS:0][3:0] res_dig;

  bcd5_carry_resolve #(.DIGITS(DIGITS)) u_res (
    .dec (col_dec),
    .dig (res_dig)
  );

  logic [SUMW-1:0] sum_comb;
  logic            bad_comb;

  assign sum_comb = res_dig;
  assign bad_comb = |col_bad;

  if (REGISTERED) begin : g_reg
    logic [SUMW-1:0] sum_d, sum_q;
    logic            bad_d, bad_q;
    logic            vld_d, vld_q;

    always_comb begin
      sum_d = sum_q;
      bad_d = bad_q;
      vld_d = in_valid;
      if (in_valid) begin
        sum_d = sum_comb;
        bad_d = bad_comb;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q <= '0;
        bad_q <= 1'b0;
        vld_q <= 1'b0;
      end else begin
        sum_q <= sum_d;
        bad_q <= bad_d;
        vld_q <= vld_d;
      end
    end

    assign sum_bcd     = sum_q;
    assign invalid_bcd = bad_q;
    assign out_valid   = vld_q;
  end else begin : g_comb
    assign sum_bcd     = sum_comb;
    assign invalid_bcd = bad_comb;
    assign out_valid   = in_valid;
  end

endmodule

// File: rtl/bcd5_sum_adder_chk.sv
module bcd5_sum_adder_chk #(
  parameter int DIGITS     = 4,
  parameter bit REGISTERED = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [4*DIGITS-1:0] op_a,
  input logic [4*DIGITS-1:0] op_b,
  input logic [4*DIGITS-1:0] op_c,
  input logic [4*DIGITS-1:0] op_d,
  input logic [4*DIGITS-1:0] op_e,
  input logic [4*DIGITS+3:0] sum_bcd,
  input logic                out_valid,
  input logic                invalid_bcd
);

  function automatic logic has_bad(logic [4*DIGITS-1:0] v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) r = 1'b1;
    return r;
  endfunction

  logic any_bad, all_zero, digits_ok;

  always_comb begin
    any_bad  = has_bad(op_a) | has_bad(op_b) | has_bad(op_c) | has_bad(op_d) | has_bad(op_e);
    all_zero = ((op_a | op_b | op_c | op_d | op_e) == '0);
    digits_ok = (sum_bcd[4*DIGITS +: 4] <= 4'd4);
    for (int i = 0; i < DIGITS; i++) if (sum_bcd[4*i +: 4] > 4'd9) digits_ok = 1'b0;
  end

  if (REGISTERED) begin : g_seq
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
    end

    // R6
    a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (out_valid == $past(in_valid)));
    // R7
    a_r7_hold_sum: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(sum_bcd) && $stable(invalid_bcd));
    // R5
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && any_bad) |=> invalid_bcd);
    a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !any_bad) |=> !invalid_bcd);
    // R9
    a_r9_zero_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && all_zero) |=> (sum_bcd == '0));
    // R2
    a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !invalid_bcd) |-> digits_ok);
  end else begin : g_cmb
    // R2
    a_r2_digit_range_c: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !any_bad) |-> digits_ok);
  end

endmodule

bind bcd5_sum_adder bcd5_sum_adder_chk #(
  .DIGITS     (DIGITS),
  .REGISTERED (REGISTERED)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .op_a        (op_a),
  .op_b        (op_b),
  .op_c        (op_c),
  .op_d        (op_d),
  .op_e        (op_e),
  .sum_bcd     (sum_bcd),
  .out_valid   (out_valid),
  .invalid_bcd (invalid_bcd)
);

// File: tb/tb_bcd5_sum_adder.sv
module tb_bcd5_sum_adder;

  logic clk;
  logic rst_n;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // four-digit instance
  logic        vb;
  logic [15:0] a, b, c, d, e;
  logic [19:0] sb;
  logic        ovb, ibb;

  bcd5_sum_adder #(.DIGITS(4), .REGISTERED(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(vb),
    .op_a(a), .op_b(b), .op_c(c), .op_d(d), .op_e(e),
    .sum_bcd(sb), .out_valid(ovb), .invalid_bcd(ibb)
  );

  // one-digit instance for the exhaustive column sweep
  logic       vs;
  logic [3:0] sa, sbb, sc, sd, se;
  logic [7:0] ss;
  logic       ovs, ibs;

  bcd5_sum_adder #(.DIGITS(1), .REGISTERED(1'b1)) dut_small (
    .clk(clk), .rst_n(rst_n), .in_valid(vs),
    .op_a(sa), .op_b(sbb), .op_c(sc), .op_d(sd), .op_e(se),
    .sum_bcd(ss), .out_valid(ovs), .invalid_bcd(ibs)
  );

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  function automatic int bcd_to_int(logic [19:0] v);
    int r = 0;
    for (int i = 4; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [19:0] int_to_bcd(int n);
    logic [19:0] r = '0;
    int m = n;
    for (int i = 0; i < 5; i++) begin
      r[4*i +: 4] = 4'(m % 10);
      m = m / 10;
    end
    return r;
  endfunction

  function automatic logic [15:0] rand_bcd();
    logic [15:0] r;
    for (int i = 0; i < 4; i++) r[4*i +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply at a falling edge, check at the next falling edge
  task automatic run_big(input logic [15:0] xa, xb, xc, xd, xe, input string req);
    logic [19:0] exp;
    a = xa; b = xb; c = xc; d = xd; e = xe; vb = 1'b1;
    exp = int_to_bcd(bcd_to_int({4'h0, xa}) + bcd_to_int({4'h0, xb}) + bcd_to_int({4'h0, xc})
                     + bcd_to_int({4'h0, xd}) + bcd_to_int({4'h0, xe}));
    @(negedge clk);
    check(sb == exp && ovb && !ibb, req, sb, exp);
  endtask

  initial begin
    rst_n = 1'b0;
    vb = 1'b0; vs = 1'b0;
    a = '0; b = '0; c = '0; d = '0; e = '0;
    sa = '0; sbb = '0; sc = '0; sd = '0; se = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(sb == '0 && !ovb && !ibb, "R8 reset", {ovb, ibb, sb[17:0]}, 20'h0);
    check(ss == '0 && !ovs && !ibs, "R8 reset small", {12'h0, ss}, 20'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: idle after reset
    check(!ovb, "R6 idle out_valid", {19'h0, ovb}, 20'h0);

    // R4: worked example
    run_big(16'h9234, 16'h4876, 16'h6542, 16'h3435, 16'h5678, "R4 example");
    check(sb == 20'h29765, "R4 example literal", sb, 20'h29765);
    // R3: all nines
    run_big(16'h9999, 16'h9999, 16'h9999, 16'h9999, 16'h9999, "R3 all nines");
    check(sb == 20'h49995, "R3 literal", sb, 20'h49995);
    // R9: all zeros
    run_big(16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, "R9 zeros");
    // R1: carry ripples across every column
    run_big(16'h9999, 16'h0001, 16'h0000, 16'h0000, 16'h0000, "R1 ripple");
    run_big(16'h1999, 16'h1999, 16'h1999, 16'h1999, 16'h2004, "R1 carry 4 chain");

    // R7: hold with changed operands
    run_big(16'h1234, 16'h1111, 16'h2222, 16'h3333, 16'h0000, "R1 before hold");
    vb = 1'b0;
    a = 16'h9999; b = 16'h00AA; c = 16'h7777;
    @(negedge clk);
    check(sb == 20'h07900 && !ibb, "R7 hold", sb, 20'h07900);
    check(!ovb, "R6 out_valid drops", {19'h0, ovb}, 20'h0);
    @(negedge clk);
    check(sb == 20'h07900 && !ibb, "R7 hold second cycle", sb, 20'h07900);

    // R5: invalid digit sets the flag
    a = 16'h00A0; b = 16'h0000; c = 16'h0000; d = 16'h0000; e = 16'h0000; vb = 1'b1;
    @(negedge clk);
    check(ibb == 1'b1, "R5 flag set", {19'h0, ibb}, 20'h1);
    a = 16'hF000; vb = 1'b1;
    @(negedge clk);
    check(ibb == 1'b1, "R5 flag set top digit", {19'h0, ibb}, 20'h1);
    vb = 1'b0;
    @(negedge clk);
    check(ibb == 1'b1, "R7 flag held", {19'h0, ibb}, 20'h1);
    run_big(16'h0005, 16'h0005, 16'h0000, 16'h0000, 16'h0000, "R5 flag clear");

    // R1, R2: random valid operands
    for (int k = 0; k < 600; k++) begin
      run_big(rand_bcd(), rand_bcd(), rand_bcd(), rand_bcd(), rand_bcd(), "R1 random");
    end
    vb = 1'b0;

    // R1, R2: exhaustive single-column sweep
    for (int i0 = 0; i0 < 10; i0++)
      for (int i1 = 0; i1 < 10; i1++)
        for (int i2 = 0; i2 < 10; i2++)
          for (int i3 = 0; i3 < 10; i3++)
            for (int i4 = 0; i4 < 10; i4++) begin
              int tot;
              logic [7:0] exs;
              sa = 4'(i0); sbb = 4'(i1); sc = 4'(i2); sd = 4'(i3); se = 4'(i4); vs = 1'b1;
              tot = i0 + i1 + i2 + i3 + i4;
              exs = {4'(tot / 10), 4'(tot % 10)};
              @(negedge clk);
              check(ss == exs && ovs && !ibs, "R1 R2 column sweep", {12'h0, ss}, {12'h0, exs});
            end
    vs = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule